// File: doc/BRIEF.md
# End-of-Interrupt Broadcast Handler with Storm Throttle

This block sits beside an interrupt routing table. When an interrupt controller signals that a handler has finished (an end-of-interrupt carrying a vector number and a trigger mode), the block walks through every routing entry, one pin per clock, and acts on each pin whose programmed vector equals the one that was retired. Every matching pin gets an acknowledge pulse. When the end-of-interrupt is level-triggered, the matching pin's remote in-service flag is cleared. If that pin is still being requested and is not masked, it is re-delivered straight away.

Each pin keeps a count of how many times in a row it has been re-delivered this way. A level source that never goes quiet would otherwise tie up the destination forever. So when the count reaches a fixed limit, the block resets it and does not re-deliver at once. Instead it arms a single countdown of about 10 ms. When the countdown runs out, one sweep re-delivers every level-triggered, unmasked pin that is requested and whose in-service flag is clear. The remote in-service flags themselves live outside the block: it reads them and emits clear strobes.

A new end-of-interrupt is accepted only while `busy` is low. The surrounding logic holds the request until it is taken.

Top module: `eoi_broadcast_unit`

## Requirements
- R1: After reset `busy` is low, no strobe is asserted, every pin's storm count is zero and no delayed sweep is pending.
- R2: A request accepted at a clock edge (`eoi_valid` high while `busy` is low) makes `busy` high for exactly NUM_PINS cycles. Pin k is examined in the k-th of these cycles (k from 0). `ack_notify[k]` pulses in that cycle if and only if pin k's vector field (`pin_vector[k*VEC_W +: VEC_W]`) equals the accepted vector, whatever the trigger mode. All matching pins are acknowledged, not only the first.
- R3: When the accepted request has `eoi_level` = 0 (edge), the scan asserts no `remote_clr` and no `redeliver`, and leaves every storm count unchanged.
- R4: When the accepted request has `eoi_level` = 1 (level), `remote_clr[k]` pulses in the same cycle as `ack_notify[k]`.
- R5: For a level match on a pin with `pin_mask[k]` = 0 and `pin_request[k]` = 1 whose count plus one is below STORM_LIMIT, `redeliver[k]` pulses in that same cycle and the count increments.
- R6: For such a pin whose count plus one reaches STORM_LIMIT, no immediate `redeliver` is issued, the count returns to zero and a delayed sweep is armed.
- R7: For a level match on a pin that is masked or not requested, the count returns to zero and no `redeliver` is issued for it by the scan. A masked pin never receives `redeliver`.
- R8: The sweep fires DELAY_CYCLES cycles after the cycle in which it was armed (DELAY_CYCLES = CLK_HZ / DELAY_DIV). In that one cycle it pulses `redeliver[k]` for every pin with `pin_level_trig[k]` = 1, `pin_request[k]` = 1, `pin_mask[k]` = 0 and `pin_remote[k]` = 0.
- R9: A deferral while a sweep is pending does not restart the countdown. A deferral in the very cycle the sweep fires arms a fresh countdown.
- R10: `eoi_valid` while `busy` is high is ignored, including in the last scan cycle.
- R11: A scan re-delivery and a sweep re-delivery that fall in the same cycle both appear on `redeliver`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_vector | input | VEC_W | Vector being retired |
| eoi_level | input | 1 | 1 = level-triggered end-of-interrupt, 0 = edge |
| pin_vector | input | NUM_PINS*VEC_W | Vector field of each routing entry, pin k at bits k*VEC_W |
| pin_level_trig | input | NUM_PINS | Entry is programmed level-triggered |
| pin_mask | input | NUM_PINS | Entry is masked |
| pin_request | input | NUM_PINS | Pin is currently requesting |
| pin_remote | input | NUM_PINS | Remote in-service flag of each entry |
| busy | output | 1 | Scan in progress; requests not accepted |
| ack_notify | output | NUM_PINS | Acknowledge pulse for a matched pin |
| remote_clr | output | NUM_PINS | Clear strobe for a pin's remote in-service flag |
| redeliver | output | NUM_PINS | Re-delivery request per pin |

## Verification
The immediate re-delivery of the pin under scan and the delayed sweep can land in the same cycle on different pins, or even on the same pin. A deferral can also coincide with the sweep firing, which tests whether the countdown re-arms. These coincidences are provoked by a long stretch of pseudo-random traffic with a short storm limit and a 12-cycle delay, so sweeps fire often while scans are running. A behavioural model predicts every strobe on every cycle and counts the cycles in which a scan re-delivery and a sweep coincided. A run in which that count stays zero is judged a failure, because it would not have exercised R11.

// File: rtl/eoi_pkg.sv
// Package: shared helpers and the trigger-mode encoding for the EOI handler.
// Assumes: nothing beyond IEEE 1800-2017.
package eoi_pkg;

    // Trigger mode carried with an end-of-interrupt
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    // Width needed to index n items, never less than one bit
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width needed to hold the value n itself
    function automatic int val_width(input int n);
        return (n > 0) ? $clog2(n + 1) : 1;
    endfunction

endpackage

// File: rtl/eoi_scan_ctrl.sv
// Module: eoi_scan_ctrl
// Accepts one end-of-interrupt request when idle and then steps an index
// over all pins, one per cycle, holding the captured vector and mode.
// Assumes: NUM_PINS >= 1; requests arriving while busy are dropped.
module eoi_scan_ctrl
    import eoi_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8,
    localparam int IDX_W   = idx_width(NUM_PINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic             req_level,
    output logic             scanning,
    output logic [IDX_W-1:0] scan_idx,
    output logic [VEC_W-1:0] scan_vector,
    output trig_e            scan_mode
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);

    logic take;
    assign take = req_valid && !scanning;

    // Scan sequencing: start on an accepted request, stop after the last pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scanning <= 1'b0;
            scan_idx <= '0;
        end else if (scanning) begin
            if (scan_idx == LAST_IDX) begin
                scanning <= 1'b0;
                scan_idx <= '0;
            end else begin
                scan_idx <= scan_idx + 1'b1;
            end
        end else if (take) begin
            scanning <= 1'b1;
            scan_idx <= '0;
        end
    end

    // Capture of the request's vector and trigger mode at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_vector <= '0;
            scan_mode   <= TRIG_EDGE;
        end else if (take) begin
            scan_vector <= req_vector;
            scan_mode   <= req_level ? TRIG_LEVEL : TRIG_EDGE;
        end
    end

endmodule

// File: rtl/eoi_storm_counter.sv
// Module: eoi_storm_counter
// Per-pin count of back-to-back EOI-driven re-deliveries. Decides, for a
// level match, between immediate re-delivery and deferral to the sweep.
// Assumes: STORM_LIMIT >= 1; 'hit' is high for at most one cycle per scan.
module eoi_storm_counter
    import eoi_pkg::*;
#(
    parameter int STORM_LIMIT = 10000,
    localparam int CNT_W      = val_width(STORM_LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic eligible,
    output logic fire_now,
    output logic defer
);

    localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(STORM_LIMIT - 1);

    logic [CNT_W-1:0] run_count;
    logic             at_limit;

    assign at_limit = (run_count == LAST_COUNT);
    assign fire_now = hit && eligible && !at_limit;
    assign defer    = hit && eligible && at_limit;

    // Count update: grow on immediate re-delivery, clear on deferral or idle pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_count <= '0;
        end else if (hit) begin
            if (fire_now) begin
                run_count <= run_count + 1'b1;
            end else begin
                run_count <= '0;
            end
        end
    end

endmodule

// File: rtl/eoi_delay_timer.sv
// Module: eoi_delay_timer
// Single shared countdown for deferred re-delivery. Arms on any deferral,
// ignores further deferrals while running, and pulses 'sweep' for one
// cycle DELAY_CYCLES cycles after arming. A deferral in the sweep cycle
// re-arms it.
// Assumes: DELAY_CYCLES >= 1.
module eoi_delay_timer
    import eoi_pkg::*;
#(
    parameter int DELAY_CYCLES = 2000000,
    localparam int TMR_W       = val_width(DELAY_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic defer_any,
    output logic sweep
);

    localparam logic [TMR_W-1:0] LAST_TICK = TMR_W'(DELAY_CYCLES - 1);

    logic             pending;
    logic [TMR_W-1:0] elapsed;

    assign sweep = pending && (elapsed == LAST_TICK);

    // Countdown: arm, run, fire, and re-arm when a deferral meets the sweep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            elapsed <= '0;
        end else if (sweep) begin
            pending <= defer_any;
            elapsed <= '0;
        end else if (pending) begin
            elapsed <= elapsed + 1'b1;
        end else if (defer_any) begin
            pending <= 1'b1;
            elapsed <= '0;
        end
    end

endmodule

// File: rtl/eoi_broadcast_unit.sv
// Module: eoi_broadcast_unit (top)
// Handles end-of-interrupt broadcasts against a routing table: scans all
// pins, acknowledges vector matches, clears remote in-service flags and
// re-delivers still-requested level pins, throttling storms through a
// per-pin counter and a shared delayed sweep.
// Assumes: routing fields and flags are held stable by the table owner;
// the remote in-service flags are stored outside and cleared on remote_clr.
module eoi_broadcast_unit
    import eoi_pkg::*;
#(
    parameter int NUM_PINS    = 24,
    parameter int VEC_W       = 8,
    parameter int STORM_LIMIT = 10000,
    parameter int CLK_HZ      = 200000000,
    parameter int DELAY_DIV   = 100
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vector,
    input  logic                      eoi_level,
    input  logic [NUM_PINS*VEC_W-1:0] pin_vector,
    input  logic [NUM_PINS-1:0]       pin_level_trig,
    input  logic [NUM_PINS-1:0]       pin_mask,
    input  logic [NUM_PINS-1:0]       pin_request,
    input  logic [NUM_PINS-1:0]       pin_remote,
    output logic                      busy,
    output logic [NUM_PINS-1:0]       ack_notify,
    output logic [NUM_PINS-1:0]       remote_clr,
    output logic [NUM_PINS-1:0]       redeliver
);

    localparam int IDX_W        = idx_width(NUM_PINS);
    localparam int DELAY_CYCLES = (CLK_HZ / DELAY_DIV > 0) ? CLK_HZ / DELAY_DIV : 1;

    logic             scanning;
    logic [IDX_W-1:0] scan_idx;
    logic [VEC_W-1:0] scan_vector;
    trig_e            scan_mode;
    logic             sweep;

    logic [NUM_PINS-1:0] pin_sel;
    logic [NUM_PINS-1:0] fire_now;
    logic [NUM_PINS-1:0] defer_pin;
    logic [NUM_PINS-1:0] sweep_hit;

    // Request acceptance and pin stepping (R2, R10)
    eoi_scan_ctrl #(
        .NUM_PINS (NUM_PINS),
        .VEC_W    (VEC_W)
    ) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (eoi_valid),
        .req_vector  (eoi_vector),
        .req_level   (eoi_level),
        .scanning    (scanning),
        .scan_idx    (scan_idx),
        .scan_vector (scan_vector),
        .scan_mode   (scan_mode)
    );

    // Per-pin match, storm counting and sweep qualification
    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        logic level_hit;

        assign pin_sel[k] = scanning && (scan_idx == IDX_W'(k))
                            && (pin_vector[k*VEC_W +: VEC_W] == scan_vector);
        assign level_hit  = pin_sel[k] && (scan_mode == TRIG_LEVEL);

        // R5, R6, R7: immediate re-delivery or deferral for this pin
        eoi_storm_counter #(
            .STORM_LIMIT (STORM_LIMIT)
        ) u_storm (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (level_hit),
            .eligible (!pin_mask[k] && pin_request[k]),
            .fire_now (fire_now[k]),
            .defer    (defer_pin[k])
        );

        // R8: pins the delayed sweep re-delivers
        assign sweep_hit[k] = sweep && pin_level_trig[k] && pin_request[k]
                              && !pin_mask[k] && !pin_remote[k];
    end

    // R8, R9: shared deferred re-delivery countdown
    eoi_delay_timer #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .defer_any (|defer_pin),
        .sweep     (sweep)
    );

    // Output strobes: R2 ack, R4 clear, R11 merged re-delivery
    always_comb begin
        busy       = scanning;
        ack_notify = pin_sel;
        remote_clr = (scan_mode == TRIG_LEVEL) ? pin_sel : '0;
        redeliver  = fire_now | sweep_hit;
    end

endmodule

// File: rtl/eoi_broadcast_chk.sv
// Module: eoi_broadcast_chk
// Property checker bound to eoi_broadcast_unit. Keeps its own copy of the
// accepted trigger mode and a run-length count of busy cycles.
module eoi_broadcast_chk #(
    parameter int NUM_PINS = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                eoi_valid,
    input logic                eoi_level,
    input logic                busy,
    input logic [NUM_PINS-1:0] ack_notify,
    input logic [NUM_PINS-1:0] remote_clr,
    input logic [NUM_PINS-1:0] redeliver,
    input logic [NUM_PINS-1:0] pin_mask
);

    logic        mode_q;
    int unsigned busy_run;

    // Track the mode of the request most recently accepted
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else if (eoi_valid && !busy) mode_q <= eoi_level;
    end

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else busy_run <= 0;
    end

    // R10
    accept_starts_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !busy) |=> busy);

    // R2
    scan_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < NUM_PINS));

    // R2
    single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_notify));

    // R4
    clear_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_clr & ~ack_notify) == '0);

    // R3
    edge_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_q) |-> (remote_clr == '0));

    // R7
    masked_no_redeliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redeliver & pin_mask) == '0);

endmodule

bind eoi_broadcast_unit eoi_broadcast_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/eoi_broadcast_unit_test.sv
// Bench: behavioural per-cycle model of the EOI handler compared on every clock.
module eoi_broadcast_unit_test;

    localparam int NP    = 6;
    localparam int VW    = 8;
    localparam int LIMIT = 3;
    localparam int DELAY = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              eoi_valid = 1'b0;
    logic [VW-1:0]     eoi_vector = '0;
    logic              eoi_level = 1'b0;
    logic [NP*VW-1:0]  pin_vector = '0;
    logic [NP-1:0]     pin_level_trig = '0;
    logic [NP-1:0]     pin_mask = '0;
    logic [NP-1:0]     pin_request = '0;
    logic [NP-1:0]     pin_remote = '0;
    logic              busy;
    logic [NP-1:0]     ack_notify;
    logic [NP-1:0]     remote_clr;
    logic [NP-1:0]     redeliver;

    eoi_broadcast_unit #(
        .NUM_PINS(NP), .VEC_W(VW), .STORM_LIMIT(LIMIT),
        .CLK_HZ(DELAY * 100), .DELAY_DIV(100)
    ) uut (.*);

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int both_cycles = 0;
    int sweeps_seen = 0;
    bit done = 1'b0;

    // reference model state
    bit m_busy = 0;
    int m_idx = 0;
    int m_vec = 0;
    bit m_lvl = 0;
    bit m_pend = 0;
    int m_t = 0;
    int m_cnt[NP];

    task automatic check_bits(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: compare at negedge, advance model, drive at posedge+1
    task automatic tick();
        logic [NP-1:0] e_ack, e_clr, e_rd;
        bit sweep_now, any_defer, any_scan_fire;
        @(negedge clk);
        e_ack = '0; e_clr = '0; e_rd = '0;
        any_defer = 0; any_scan_fire = 0;
        sweep_now = rst_n && m_pend && (m_t == DELAY - 1);
        for (int p = 0; p < NP; p++) begin
            bit sel, elig, fire, dfr;
            sel  = rst_n && m_busy && (m_idx == p) && (int'(pin_vector[p*VW +: VW]) == m_vec);
            elig = !pin_mask[p] && pin_request[p];
            fire = sel && m_lvl && elig && (m_cnt[p] + 1 < LIMIT);
            dfr  = sel && m_lvl && elig && (m_cnt[p] + 1 >= LIMIT);
            e_ack[p] = sel;
            e_clr[p] = sel && m_lvl;
            e_rd[p]  = fire || (sweep_now && pin_level_trig[p] && pin_request[p]
                                && !pin_mask[p] && !pin_remote[p]);
            if (fire) any_scan_fire = 1;
            if (dfr) any_defer = 1;
            if (sel && m_lvl) m_cnt[p] = fire ? m_cnt[p] + 1 : 0;
        end
        if (any_scan_fire && sweep_now) both_cycles++;
        if (sweep_now) sweeps_seen++;
        // R2 R10 busy, R2 ack, R3 R4 clear, R5 R6 R7 R8 R9 R11 redeliver
        check_bits("R2/R10 busy", {{(NP-1){1'b0}}, busy}, {{(NP-1){1'b0}}, rst_n && m_busy});
        check_bits("R2 ack_notify", ack_notify, e_ack);
        check_bits("R3/R4 remote_clr", remote_clr, e_clr);
        check_bits("R5/R6/R7/R8/R9/R11 redeliver", redeliver, e_rd);
        if (!rst_n) begin
            m_busy = 0; m_idx = 0; m_pend = 0; m_t = 0;
            for (int p = 0; p < NP; p++) m_cnt[p] = 0;
        end else begin
            if (sweep_now) begin
                m_pend = any_defer; m_t = 0;
            end else if (m_pend) begin
                m_t++;
            end else if (any_defer) begin
                m_pend = 1; m_t = 0;
            end
            if (m_busy) begin
                if (m_idx == NP - 1) begin m_busy = 0; m_idx = 0; end
                else m_idx++;
            end else if (eoi_valid) begin
                m_busy = 1; m_idx = 0; m_vec = int'(eoi_vector); m_lvl = eoi_level;
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [VW-1:0] v, input logic lvl);
        eoi_valid = 1'b1; eoi_vector = v; eoi_level = lvl;
        tick();
        eoi_valid = 1'b0;
    endtask

    initial begin
        for (int p = 0; p < NP; p++) m_cnt[p] = 0;
        repeat (2) @(posedge clk);
        #1;
        tick(); tick();
        rst_n = 1'b1;
        // R1: idle outputs straight after reset
        tick();
        check_bits("R1 busy after reset", {{(NP-1){1'b0}}, busy}, '0);
        pin_vector = {8'h66, 8'h30, 8'h55, 8'h30, 8'h41, 8'h30};
        pin_level_trig = 6'b010111;
        pin_request = 6'b111111;
        pin_mask = 6'b000100;
        // R3: edge end-of-interrupt only acknowledges
        send(8'h30, 1'b0);
        repeat (NP + 2) tick();
        // R4 R5 R7: level end-of-interrupt, pin 2 masked
        send(8'h30, 1'b1);
        repeat (NP + 2) tick();
        // R6: repeated level ends reach the storm limit on pins 0 and 4
        for (int i = 0; i < LIMIT + 1; i++) begin
            send(8'h30, 1'b1);
            repeat (NP + 1) tick();
        end
        // R8: wait out the sweep
        repeat (DELAY + 4) tick();
        // R10: request while busy is dropped
        send(8'h41, 1'b1);
        eoi_valid = 1'b1; eoi_vector = 8'h30; eoi_level = 1'b1;
        repeat (NP) tick();
        eoi_valid = 1'b0;
        repeat (3) tick();
        // R9 R11: pseudo-random traffic to mix sweeps, deferrals and scans
        for (int c = 0; c < 6000; c++) begin
            int r;
            r = $urandom_range(0, 2);
            eoi_valid   = ($urandom_range(0, 1) == 1);
            eoi_vector  = (r == 0) ? 8'h30 : (r == 1) ? 8'h41 : 8'h66;
            eoi_level   = ($urandom_range(0, 3) != 0);
            pin_request = ~NP'($urandom_range(0, 7));
            pin_remote  = NP'($urandom_range(0, 3));
            pin_mask    = ($urandom_range(0, 9) == 0) ? NP'($urandom_range(0, 63)) : '0;
            tick();
        end
        eoi_valid = 1'b0;
        repeat (NP + 2) tick();
        // R11: scan and sweep re-delivery coincided at least once
        total++;
        if (both_cycles == 0) begin
            bad++;
            $display("FAIL R11 coincident cycles actual=%0d expected=>0", both_cycles);
        end
        // R8: sweeps were observed
        total++;
        if (sweeps_seen == 0) begin
            bad++;
            $display("FAIL R8 sweeps actual=%0d expected=>0", sweeps_seen);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule